// File: doc/BRIEF.md
# Floppy Sector Transfer Handshake Engine

This block is the byte-moving half of a floppy disk controller, as a CPU sees it when it polls the controller instead of taking interrupts. The host first loads a track value and a sector value. It then writes a read-sector or write-sector command. The engine raises busy, waits out a fixed spin-up delay, and moves one sector of bytes between a drive-side byte stream and the host's data register.

Each byte is paced by a data-request flag that the host polls in the status register. When the host does not service a request before the next byte slot arrives from the drive, the engine records a lost-data condition. On a read it drops the incoming byte. On a write it sends a zero byte.

The track and sector values are presented to the drive side only for matching the on-disk sector ID; this block never moves the head. The side-select bit from an external latch is passed straight through.

Top module: `fdc_xfer`

## Requirements
- R1: After reset the status register (address 0) reads 0x00, the drive-side `drv_in_ready` and `drv_out_valid` are low, and `motor_on` is low.
- R2: A write of 0x88 to address 0 while idle starts a sector read, and a write of 0xA8 starts a sector write. Status bit 0 (busy) and `motor_on` are high from the clock edge that takes the command.
- R3: Any other command value written while idle leaves the engine idle. Any command written while busy is ignored, and the running transfer keeps its direction.
- R4: After a command is accepted, the first byte slot opens exactly `SPIN_CYC` clock cycles later (`drv_in_ready` or `drv_out_valid` rises).
- R5: On a read, each byte accepted from the drive (`drv_in_valid` with `drv_in_ready`) is placed in the data register (address 3) and sets status bit 1 (data request).
- R6: A host read or write of address 3 clears data request.
- R7: On a write, data request is set when the transfer phase opens and again after each slot except the last. At a slot the drive receives the byte the host last wrote to address 3.
- R8: A slot that arrives while data request is still set sets status bit 2 (lost data). On a read the byte is discarded and the data register keeps its value; on a write `drv_out_data` is 0x00. Lost data stays set until the next accepted command clears it.
- R9: Busy clears once `SECTOR_BYTES` slots have passed and no data request is pending. On a read this means after the host has read the last byte.
- R10: Addresses 1 and 2 hold the track and sector values, are readable by the host, and drive `drv_track` and `drv_sector`. Writes to them while busy are ignored.
- R11: `drv_side` equals bit 0 of `side_sel` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Host register select |
| wr | input | 1 | Host write strobe |
| rd | input | 1 | Host read strobe |
| addr | input | 2 | Register address: 0 command/status, 1 track, 2 sector, 3 data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| side_sel | input | 8 | External latch value; bit 0 selects side |
| drv_in_valid | input | 1 | Drive offers a read byte |
| drv_in_data | input | 8 | Read byte from drive |
| drv_in_ready | output | 1 | Engine open for a read slot |
| drv_out_ready | input | 1 | Drive takes a write byte this cycle |
| drv_out_valid | output | 1 | Engine has a write slot open |
| drv_out_data | output | 8 | Byte sent to the drive |
| drv_track | output | 8 | Track value for ID matching |
| drv_sector | output | 8 | Sector value for ID matching |
| drv_side | output | 1 | Side select to drive |
| motor_on | output | 1 | Motor enable, high while busy |

## Verification
The assertions assume that the host raises `rd` or `wr` for only one cycle per access. They also assume that the drive offers bytes only on one side at a time, through `drv_in_valid` in a read and `drv_out_ready` in a write. The bench drives every host access as a single-cycle strobe, set up at the falling edge. It raises drive-side strobes only after seeing the matching slot signal high. It creates lost-data slots deliberately by skipping a host access before a slot.

// File: rtl/fdc_xfer.sv
module fdc_xfer #(
  parameter int SECTOR_BYTES = 256,
  parameter int SPIN_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] side_sel,
  input  logic       drv_in_valid,
  input  logic [7:0] drv_in_data,
  output logic       drv_in_ready,
  input  logic       drv_out_ready,
  output logic       drv_out_valid,
  output logic [7:0] drv_out_data,
  output logic [7:0] drv_track,
  output logic [7:0] drv_sector,
  output logic       drv_side,
  output logic       motor_on
);
  localparam int CW = $clog2(SECTOR_BYTES + 1);
  localparam int SW = $clog2(SPIN_CYC + 1);
  localparam logic [7:0] CMD_RD = 8'h88;
  localparam logic [7:0] CMD_WR = 8'hA8;

  typedef enum logic [1:0] {IDLE, SPIN, XFER} state_t;

  state_t        st;
  logic          is_write, drq, lost;
  logic [CW-1:0] cnt;
  logic [SW-1:0] spin;
  logic [7:0]    data_reg, trk, sec;

  wire busy     = (st != IDLE);
  wire cmd_wr   = cs && wr && addr == 2'd0;
  wire data_acc = cs && (wr || rd) && addr == 2'd3;
  wire start_rd = cmd_wr && !busy && wdata == CMD_RD;
  wire start_wr = cmd_wr && !busy && wdata == CMD_WR;
  wire drq_eff  = drq && !data_acc;
  wire slot     = (drv_in_valid && drv_in_ready) || (drv_out_valid && drv_out_ready);

  assign drv_in_ready  = (st == XFER) && !is_write && cnt != '0;
  assign drv_out_valid = (st == XFER) && is_write && cnt != '0;
  assign drv_out_data  = (data_acc && wr) ? wdata : (drq ? 8'h00 : data_reg);
  assign drv_track     = trk;
  assign drv_sector    = sec;
  assign drv_side      = side_sel[0];
  assign motor_on      = busy;

  always_comb begin
    case (addr)
      2'd0:    rdata = {5'b0, lost, drq, busy};
      2'd1:    rdata = trk;
      2'd2:    rdata = sec;
      default: rdata = data_reg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      is_write <= 1'b0;
      drq <= 1'b0;
      lost <= 1'b0;
      cnt <= '0;
      spin <= '0;
      data_reg <= '0;
      trk <= '0;
      sec <= '0;
    end else begin
      if (data_acc) begin
        drq <= 1'b0;
        if (wr) data_reg <= wdata;
      end
      if (cs && wr && addr == 2'd1 && !busy) trk <= wdata;
      if (cs && wr && addr == 2'd2 && !busy) sec <= wdata;
      case (st)
        IDLE: if (start_rd || start_wr) begin
          st <= SPIN;
          is_write <= start_wr;
          spin <= SW'(SPIN_CYC - 1);
          cnt <= CW'(SECTOR_BYTES);
          lost <= 1'b0;
          drq <= 1'b0;
        end
        SPIN: if (spin == '0) begin
          st <= XFER;
          if (is_write) drq <= 1'b1;
        end else begin
          spin <= spin - 1'b1;
        end
        XFER: begin
          if (slot) begin
            cnt <= cnt - 1'b1;
            if (drq_eff) lost <= 1'b1;
            else if (!is_write) begin
              data_reg <= drv_in_data;
              drq <= 1'b1;
            end
            if (is_write && cnt != CW'(1)) drq <= 1'b1;
          end else if (cnt == '0 && !drq_eff) begin
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module fdc_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic       rd,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       busy,
  input logic       drq,
  input logic       lost,
  input logic       drv_in_valid,
  input logic       drv_in_ready,
  input logic       drv_out_ready,
  input logic       drv_out_valid
);
  wire cmd_wr  = cs && wr && addr == 2'd0;
  wire good    = wdata == 8'h88 || wdata == 8'hA8;
  wire slot    = (drv_in_valid && drv_in_ready) || (drv_out_valid && drv_out_ready);
  wire spin_ph = busy && !drv_in_ready && !drv_out_valid;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && good |=> busy); // R2
  AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && !good |=> !busy); // R3
  AST_DRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs && (wr || rd) && addr == 2'd3 && !slot && !spin_ph |=> !drq); // R6
  AST_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lost && !cmd_wr |=> lost); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drv_in_ready && !drv_out_valid && !drq); // R1
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_in_ready && drv_out_valid)); // R7
endmodule

bind fdc_xfer fdc_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
  .wdata(wdata), .busy(busy), .drq(drq), .lost(lost),
  .drv_in_valid(drv_in_valid), .drv_in_ready(drv_in_ready),
  .drv_out_ready(drv_out_ready), .drv_out_valid(drv_out_valid)
);

// File: tb/fdc_xfer_test.sv
module fdc_xfer_test;
  localparam int NB = 8;
  localparam int SP = 4;
  localparam logic [7:0] VEC [NB] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hE7};

  logic clk = 0, rst_n = 0;
  logic cs = 0, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, side_sel = 0;
  logic drv_in_valid = 0, drv_out_ready = 0;
  logic [7:0] drv_in_data = 0, drv_out_data, drv_track, drv_sector;
  logic drv_in_ready, drv_out_valid, drv_side, motor_on;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  fdc_xfer #(.SECTOR_BYTES(NB), .SPIN_CYC(SP)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; wr = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a; #1 d = rdata;
    @(posedge clk); #1 cs = 0; rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!(drv_in_ready || drv_out_valid) && n < 100) begin @(posedge clk); #1 n++; end
  endtask

  task automatic drive_in(input logic [7:0] b);
    @(negedge clk); drv_in_valid = 1; drv_in_data = b;
    @(posedge clk); #1 drv_in_valid = 0;
  endtask

  task automatic out_slot(output logic [7:0] b);
    @(negedge clk); drv_out_ready = 1; #1 b = drv_out_data;
    @(posedge clk); #1 drv_out_ready = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    peek(0, v); check("R1 status", v, 8'h00);
    check("R1 ready", {drv_in_ready, drv_out_valid, motor_on}, 3'b000);

    // R11 side passthrough
    side_sel = 8'hFE; #1 check("R11 side0", drv_side, 1'b0);
    side_sel = 8'h01; #1 check("R11 side1", drv_side, 1'b1);

    // R10 track/sector
    host_wr(1, 8'h27); host_wr(2, 8'h09);
    host_rd(1, v); check("R10 track rd", v, 8'h27);
    host_rd(2, v); check("R10 sector rd", v, 8'h09);
    check("R10 drive ids", {drv_track, drv_sector}, 16'h2709);

    // R3 bad command
    host_wr(0, 8'h10);
    peek(0, v); check("R3 bad cmd idle", v, 8'h00);

    // R2/R4 read start, table walk for R5/R6
    host_wr(0, 8'h88);
    check("R2 busy", {motor_on, rdata[0]}, 2'b11);
    wait_ready(n); check("R4 spin cycles", n, SP);
    host_wr(0, 8'hA8); host_wr(1, 8'h55);
    check("R3 dir kept", {drv_in_ready, drv_out_valid}, 2'b10);
    check("R10 track locked", drv_track, 8'h27);
    for (int i = 0; i < NB; i++) begin
      drive_in(VEC[i]);
      peek(0, v); check("R5 drq set", v[1], 1'b1);
      host_rd(3, v); check("R5 data", v, VEC[i]);
      peek(0, v); check("R6 drq clear", v[1], 1'b0);
    end
    peek(0, v); check("R9 read done", v, 8'h00);

    // R8 lost on read
    host_wr(0, 8'h88);
    wait_ready(n);
    drive_in(8'h11); drive_in(8'h22);
    peek(0, v); check("R8 lost read", v, 8'h07);
    host_rd(3, v); check("R8 byte dropped", v, 8'h11);
    for (int i = 2; i < NB - 1; i++) begin drive_in(8'h40 + 8'(i)); host_rd(3, v); end
    drive_in(8'h99);
    peek(0, v); check("R9 busy until last read", v[0], 1'b1);
    host_rd(3, v); check("R9 last byte", v, 8'h99);
    peek(0, v); check("R9 done keeps lost", v, 8'h04);

    // R7 write, with lost slot at byte 5
    host_wr(0, 8'hA8);
    peek(0, v); check("R8 lost cleared", v[2], 1'b0);
    wait_ready(n); check("R4 write spin", n, SP);
    peek(0, v); check("R7 drq on open", v[1], 1'b1);
    for (int i = 0; i < NB; i++) begin
      if (i == 5) begin
        out_slot(v); check("R8 zero sent", v, 8'h00);
      end else begin
        host_wr(3, VEC[i]);
        out_slot(v); check("R7 byte out", v, VEC[i]);
      end
      peek(0, v);
      if (i < NB - 1) check("R7 drq again", v[1], 1'b1);
    end
    peek(0, v); check("R9 write done", v, 8'h04);
    check("R9 motor off", motor_on, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule